// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit computes the addresses for one data memory port of a signal-processing datapath. A delay line, a coefficient table or an FFT buffer can then be walked at one access per clock. It holds a bank of address registers. Register 0 doubles as the step (index) register. Each register also carries its own buffer-size exponent `k`, which describes a circular buffer of 2^k words.

On each requested operation, the unit drives the selected register's current value as the access address. In the same clock edge it writes back the post-modified value. The update can be linear or circular by ±1 or by ±step. Circular updates wrap inside the buffer by masking: only the low `k` bits change. A third mode adds or subtracts the step with the carry running from the most significant bit toward bit 0. This mode produces bit-reversed FFT orderings.

A separate write path loads either a register's address or its size exponent. That write path wins over an update to the same register in the same cycle. The memory itself and the instruction decoder lie outside the block.

Top module: `agu_core`

## Requirements
- R1: After synchronous reset, every address register reads 0 and every size exponent equals ADDR_W, so that ±1 updates wrap over the full address range.
- R2: While `op_valid` is high, `addr_valid` is high and `addr_out` shows the value before the update. For codes 1 (read step) and 8 (step increment), `addr_out` shows register 0. For every other code, it shows the register picked by `op_sel`. The updated value is visible from the next cycle.
- R3: Code 2 adds 1 and code 3 subtracts 1 from the selected register, modulo 2^k. The low k bits wrap and the bits above them keep their value.
- R4: Code 4 adds register 0 to the selected register, and code 5 subtracts it. Both use the same modulo 2^k rule as R3.
- R5: Code 6 adds register 0 to the selected register, and code 7 subtracts it, with the carry or borrow running from bit ADDR_W-1 down toward bit 0. Any carry out of bit 0 is lost and the size exponent is not applied. With step 2^(m-1) on an aligned base, this mode visits the bit-reversed order of 2^m entries.
- R6: Code 8 adds 1 to register 0 over the full width, whatever its size exponent.
- R7: Code 0 (read address), code 1 (read step) and codes 9 to 15 leave all registers unchanged.
- R8: A write with `wr_en` high loads register `wr_sel`. With `wr_field` = 0 it loads the address from `wr_data`. With `wr_field` = 1 it loads the size exponent. A write to the address field takes priority over an update of the same register in the same cycle, while an update of another register still happens.
- R9: When a size exponent is written, any value above ADDR_W is stored as ADDR_W. An exponent of 0 makes ±1 and ±step updates leave the register unchanged.
- R10: With `op_valid` low, `addr_valid` is low and no register changes, whatever `op_code` and `op_sel` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An address operation is requested this cycle |
| op_sel | input | $clog2(NUM_REGS) | Register the operation applies to |
| op_code | input | 4 | Operation code (see R2 to R7) |
| wr_en | input | 1 | Load request |
| wr_field | input | 1 | 0 loads the address, 1 loads the size exponent |
| wr_sel | input | $clog2(NUM_REGS) | Register to load |
| wr_data | input | ADDR_W | Value to load |
| addr_out | output | ADDR_W | Address for the memory access |
| addr_valid | output | 1 | `addr_out` carries an access address |

## Verification
The bench builds the unit with ADDR_W = 8 and NUM_REGS = 4. This puts the full-range wrap from 0xFF to 0x00 and the clamping of size exponents above 8 within a few cycles. It also makes the whole eight-entry bit-reversed walk easy to follow by hand. With four registers, the step register, a circular register and an independently written register can all take part in the same-cycle priority case.

// File: rtl/agu_pkg.sv
// Shared definitions for the address generation unit.
// Assumes op_code values outside the listed set behave as plain reads.
package agu_pkg;

    typedef enum logic [3:0] {
        OP_RD_ADDR  = 4'd0,
        OP_RD_STEP  = 4'd1,
        OP_INC      = 4'd2,
        OP_DEC      = 4'd3,
        OP_ADD_STEP = 4'd4,
        OP_SUB_STEP = 4'd5,
        OP_REV_ADD  = 4'd6,
        OP_REV_SUB  = 4'd7,
        OP_STEP_INC = 4'd8
    } agu_op_e;

    // True for codes that write a post-modified value back
    function automatic logic op_updates(input agu_op_e op);
        case (op)
            OP_INC, OP_DEC, OP_ADD_STEP, OP_SUB_STEP,
            OP_REV_ADD, OP_REV_SUB, OP_STEP_INC: op_updates = 1'b1;
            default:                             op_updates = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/agu_revadd.sv
// Reverse-carry adder: adds or subtracts with carry moving from the MSB
// toward the LSB, by mirroring both operands, using a normal adder and
// mirroring the result. Carry out of bit 0 is dropped.
module agu_revadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);

    logic [W-1:0] ra;
    logic [W-1:0] rb;
    logic [W-1:0] rs;

    // Mirror the operands and the result bit by bit
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign ra[i] = a[W-1-i];
        assign rb[i] = b[W-1-i];
        assign y[i]  = rs[W-1-i];
    end

    // Ordinary add or subtract in the mirrored domain
    assign rs = sub ? (ra - rb) : (ra + rb);

endmodule

// File: rtl/agu_update.sv
// Post-modify computation for one address operand.
// Linear and step updates wrap modulo 2^k by masking the low k bits; the
// reverse-carry codes work over the full width; step increment ignores k.
// Assumes k never exceeds ADDR_W (the register bank clamps it).
module agu_update
    import agu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int K_W    = $clog2(ADDR_W + 1)
) (
    input  agu_op_e           op,
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] step,
    input  logic [K_W-1:0]    k,
    output logic [ADDR_W-1:0] nxt
);

    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] delta;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] rev_y;

    // Build the modulo mask: bit i is set when i lies below k
    always_comb begin
        for (int i = 0; i < ADDR_W; i++) begin
            mask[i] = (i < int'(k));
        end
    end

    // Pick the signed increment for the linear and step codes
    always_comb begin
        case (op)
            OP_INC, OP_STEP_INC: delta = ONE;
            OP_DEC:              delta = ~ADDR_W'(0);
            OP_ADD_STEP:         delta = step;
            OP_SUB_STEP:         delta = ~step + ONE;
            default:             delta = '0;
        endcase
    end

    assign sum = cur + delta;

    agu_revadd #(.W(ADDR_W)) u_revadd (
        .a   (cur),
        .b   (step),
        .sub (op == OP_REV_SUB),
        .y   (rev_y)
    );

    // Merge: masked wrap for circular codes, raw result for the others
    always_comb begin
        case (op)
            OP_REV_ADD, OP_REV_SUB: nxt = rev_y;
            OP_STEP_INC:            nxt = sum;
            default:                nxt = (cur & ~mask) | (sum & mask);
        endcase
    end

endmodule

// File: rtl/agu_bank.sv
// Bank of address registers, each with a buffer-size exponent.
// A load from the write path beats a same-cycle update of the same
// address register; size writes above ADDR_W are clamped to ADDR_W.
// Assumes NUM_REGS is a power of two so every select value is valid.
module agu_bank #(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 8,
    parameter int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    parameter int K_W      = $clog2(ADDR_W + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_field,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [ADDR_W-1:0]            wr_data,
    input  logic                         upd_en,
    input  logic [SEL_W-1:0]             upd_sel,
    input  logic [ADDR_W-1:0]            upd_val,
    input  logic [SEL_W-1:0]             rd_sel,
    output logic [ADDR_W-1:0]            rd_addr,
    output logic [K_W-1:0]               rd_k,
    output logic [ADDR_W-1:0]            step_val,
    output logic [NUM_REGS*ADDR_W-1:0]   ar_flat,
    output logic [NUM_REGS*K_W-1:0]      k_flat
);

    localparam logic [K_W-1:0]    K_FULL   = K_W'(ADDR_W);
    localparam logic [ADDR_W-1:0] K_FULL_D = ADDR_W'(ADDR_W);

    logic [ADDR_W-1:0] ar_q [NUM_REGS];
    logic [K_W-1:0]    k_q  [NUM_REGS];
    logic [K_W-1:0]    k_in;

    // Clamp an incoming size exponent to the address width
    assign k_in = (wr_data > K_FULL_D) ? K_FULL : wr_data[K_W-1:0];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic hit_wr;
        logic hit_upd;

        assign hit_wr  = wr_en && (wr_sel == SEL_W'(g));
        assign hit_upd = upd_en && (upd_sel == SEL_W'(g));

        // Address register: load wins over post-modify
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ar_q[g] <= '0;
            end else if (hit_wr && !wr_field) begin
                ar_q[g] <= wr_data;
            end else if (hit_upd) begin
                ar_q[g] <= upd_val;
            end
        end

        // Size exponent: only the write path touches it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                k_q[g] <= K_FULL;
            end else if (hit_wr && wr_field) begin
                k_q[g] <= k_in;
            end
        end

        assign ar_flat[g*ADDR_W +: ADDR_W] = ar_q[g];
        assign k_flat[g*K_W +: K_W]        = k_q[g];
    end

    assign rd_addr  = ar_q[rd_sel];
    assign rd_k     = k_q[rd_sel];
    assign step_val = ar_q[0];

endmodule

// File: rtl/agu_core.sv
// Top of the address generation unit. Drives the pre-update value of the
// selected register (or of the step register) as the access address and
// writes back the post-modified value at the same clock edge.
// Assumes one operation per cycle; op_code values 9..15 act as reads.
module agu_core
    import agu_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SEL_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int K_W     = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [SEL_W-1:0]  op_sel,
    input  logic [3:0]        op_code,
    input  logic              wr_en,
    input  logic              wr_field,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_valid
);

    agu_op_e                    op;
    logic                       use_step;
    logic [ADDR_W-1:0]          sel_addr;
    logic [K_W-1:0]             sel_k;
    logic [ADDR_W-1:0]          step_q;
    logic [ADDR_W-1:0]          operand;
    logic [ADDR_W-1:0]          nxt_val;
    logic                       upd_en;
    logic [SEL_W-1:0]           upd_sel;
    logic [NUM_REGS*ADDR_W-1:0] ar_flat;
    logic [NUM_REGS*K_W-1:0]    k_flat;

    assign op = agu_op_e'(op_code);

    // Step-oriented codes take register 0 as their operand
    assign use_step = (op == OP_RD_STEP) || (op == OP_STEP_INC);
    assign operand  = use_step ? step_q : sel_addr;

    // Write-back request and its target register
    assign upd_en  = op_valid && op_updates(op);
    assign upd_sel = (op == OP_STEP_INC) ? '0 : op_sel;

    agu_bank #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W),
        .K_W      (K_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_field (wr_field),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .upd_en   (upd_en),
        .upd_sel  (upd_sel),
        .upd_val  (nxt_val),
        .rd_sel   (op_sel),
        .rd_addr  (sel_addr),
        .rd_k     (sel_k),
        .step_val (step_q),
        .ar_flat  (ar_flat),
        .k_flat   (k_flat)
    );

    agu_update #(
        .ADDR_W (ADDR_W),
        .K_W    (K_W)
    ) u_update (
        .op   (op),
        .cur  (operand),
        .step (step_q),
        .k    (sel_k),
        .nxt  (nxt_val)
    );

    assign addr_out   = operand;
    assign addr_valid = op_valid;

endmodule

// File: rtl/agu_core_sva.sv
// Property checker for agu_core, attached through bind. Observes the
// ports together with the register bank contents exposed by the top.
module agu_core_sva #(
    parameter int ADDR_W   = 16,
    parameter int NUM_REGS = 8,
    parameter int SEL_W    = 3,
    parameter int K_W      = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       op_valid,
    input logic [SEL_W-1:0]           op_sel,
    input logic [3:0]                 op_code,
    input logic                       wr_en,
    input logic                       wr_field,
    input logic [SEL_W-1:0]           wr_sel,
    input logic [ADDR_W-1:0]          wr_data,
    input logic [ADDR_W-1:0]          addr_out,
    input logic                       addr_valid,
    input logic [NUM_REGS*ADDR_W-1:0] ar_flat,
    input logic [NUM_REGS*K_W-1:0]    k_flat
);

    localparam logic [K_W-1:0] K_FULL = K_W'(ADDR_W);

    // R10: idle cycles change nothing
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !wr_en) |=> (ar_flat == $past(ar_flat)) && (k_flat == $past(k_flat)));

    // R10: no access is flagged without a request
    p_valid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> !addr_valid);

    // R7: read codes leave the bank alone
    p_read_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && (op_code <= 4'd1 || op_code >= 4'd9)) |=> (ar_flat == $past(ar_flat)));

    // R6: step increment bumps register 0 by one over the full width
    p_step_inc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !wr_en && op_code == 4'd8) |=> (ar_flat[ADDR_W-1:0] == $past(addr_out) + ADDR_W'(1)));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_chk
        // R8: a load of the address field lands regardless of any update
        p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !wr_field && wr_sel == SEL_W'(g)) |=> (ar_flat[g*ADDR_W +: ADDR_W] == $past(wr_data)));

        // R2: the access address is the value held before the update
        p_pre_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op_sel == SEL_W'(g) && op_code >= 4'd2 && op_code <= 4'd7)
                |-> (addr_out == ar_flat[g*ADDR_W +: ADDR_W]));

        // R3: full-range increment is a plain +1
        p_lin_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && !wr_en && op_code == 4'd2 && op_sel == SEL_W'(g) && g != 0
                && k_flat[g*K_W +: K_W] == K_FULL)
                |=> (ar_flat[g*ADDR_W +: ADDR_W] == $past(addr_out) + ADDR_W'(1)));

        // R9: stored exponents never exceed the width
        p_k_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
            k_flat[g*K_W +: K_W] <= K_FULL);
    end

endmodule

bind agu_core agu_core_sva #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS),
    .SEL_W    (SEL_W),
    .K_W      (K_W)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .op_code    (op_code),
    .wr_en      (wr_en),
    .wr_field   (wr_field),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .ar_flat    (ar_flat),
    .k_flat     (k_flat)
);

// File: tb/agu_core_tb.sv
`timescale 1ns/1ps
module agu_core_tb;
    import agu_pkg::*;

    localparam int AW = 8;
    localparam int NR = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_valid = 1'b0;
    logic [SW-1:0] op_sel = '0;
    logic [3:0]    op_code = '0;
    logic          wr_en = 1'b0;
    logic          wr_field = 1'b0;
    logic [SW-1:0] wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic [AW-1:0] addr_out;
    logic          addr_valid;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    agu_core #(.ADDR_W(AW), .NUM_REGS(NR)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_sel     (op_sel),
        .op_code    (op_code),
        .wr_en      (wr_en),
        .wr_field   (wr_field),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .addr_out   (addr_out),
        .addr_valid (addr_valid)
    );

    task automatic check(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One operation: drive after a falling edge, sample before the rising edge
    task automatic issue(input logic [SW-1:0] sel, input agu_op_e code, output logic [AW-1:0] got);
        @(negedge clk);
        op_valid = 1'b1; op_sel = sel; op_code = code;
        #1 got = addr_out;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic peek(input logic [SW-1:0] sel, output logic [AW-1:0] got);
        issue(sel, OP_RD_ADDR, got);
    endtask

    task automatic wreg(input logic [SW-1:0] sel, input logic fld, input logic [AW-1:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_field = fld; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [AW-1:0] v;
        for (int r = 0; r < NR; r++) begin
            peek(SW'(r), v);
            check("R1 register zero after reset", v, 8'h00);
        end
        wreg(2'd1, 1'b0, 8'hFF);
        issue(2'd1, OP_INC, v);
        peek(2'd1, v);
        check("R1 default size wraps full range", v, 8'h00);
    endtask

    task automatic t_pre_update();
        logic [AW-1:0] v;
        wreg(2'd2, 1'b0, 8'h10);
        issue(2'd2, OP_INC, v);
        check("R2 pre-update address on inc", v, 8'h10);
        peek(2'd2, v);
        check("R2 updated value next cycle", v, 8'h11);
        issue(2'd2, OP_DEC, v);
        check("R2 pre-update address on dec", v, 8'h11);
        peek(2'd2, v);
        check("R3 linear decrement", v, 8'h10);
        wreg(2'd0, 1'b0, 8'h05);
        issue(2'd2, OP_RD_STEP, v);
        check("R2 read step shows register 0", v, 8'h05);
    endtask

    task automatic t_circ_unit();
        logic [AW-1:0] v;
        wreg(2'd3, 1'b1, 8'd2);
        wreg(2'd3, 1'b0, 8'h45);
        issue(2'd3, OP_INC, v);
        issue(2'd3, OP_INC, v);
        check("R3 second inc address", v, 8'h46);
        issue(2'd3, OP_INC, v);
        peek(2'd3, v);
        check("R3 inc wraps in 4-entry buffer", v, 8'h44);
        issue(2'd3, OP_DEC, v);
        peek(2'd3, v);
        check("R3 dec wraps in 4-entry buffer", v, 8'h47);
    endtask

    task automatic t_circ_step();
        logic [AW-1:0] v;
        wreg(2'd0, 1'b0, 8'h03);
        wreg(2'd2, 1'b1, 8'd3);
        wreg(2'd2, 1'b0, 8'h21);
        issue(2'd2, OP_ADD_STEP, v);
        issue(2'd2, OP_ADD_STEP, v);
        check("R4 add step", v, 8'h24);
        issue(2'd2, OP_ADD_STEP, v);
        peek(2'd2, v);
        check("R4 add step wraps modulo 8", v, 8'h22);
        issue(2'd2, OP_SUB_STEP, v);
        peek(2'd2, v);
        check("R4 sub step wraps modulo 8", v, 8'h27);
    endtask

    task automatic t_bitrev();
        logic [AW-1:0] v;
        logic [AW-1:0] seq [8] = '{8'h50, 8'h54, 8'h52, 8'h56, 8'h51, 8'h55, 8'h53, 8'h57};
        wreg(2'd0, 1'b0, 8'h04);
        wreg(2'd1, 1'b0, 8'h50);
        for (int i = 0; i < 8; i++) begin
            issue(2'd1, OP_REV_ADD, v);
            check("R5 bit-reversed walk", v, seq[i]);
        end
        peek(2'd1, v);
        check("R5 reverse carry drops off bit 0", v, 8'h50);
        issue(2'd1, OP_REV_SUB, v);
        peek(2'd1, v);
        check("R5 reverse borrow", v, 8'h57);
    endtask

    task automatic t_step_inc();
        logic [AW-1:0] v;
        wreg(2'd0, 1'b1, 8'd1);
        wreg(2'd0, 1'b0, 8'hFE);
        issue(2'd3, OP_STEP_INC, v);
        check("R6 step inc shows old step", v, 8'hFE);
        issue(2'd3, OP_RD_STEP, v);
        check("R6 step incremented ignoring size", v, 8'hFF);
        issue(2'd2, OP_STEP_INC, v);
        peek(2'd0, v);
        check("R6 step wraps full width", v, 8'h00);
    endtask

    task automatic t_read_hold();
        logic [AW-1:0] v;
        wreg(2'd0, 1'b0, 8'h07);
        wreg(2'd3, 1'b0, 8'h9C);
        issue(2'd3, OP_RD_ADDR, v);
        issue(2'd3, OP_RD_ADDR, v);
        check("R7 read address holds", v, 8'h9C);
        issue(2'd3, OP_RD_STEP, v);
        issue(2'd3, agu_op_e'(4'd12), v);
        check("R7 unused code reads selected", v, 8'h9C);
        peek(2'd3, v);
        check("R7 register unchanged after reads", v, 8'h9C);
        peek(2'd0, v);
        check("R7 step unchanged after reads", v, 8'h07);
    endtask

    task automatic t_wr_prio();
        logic [AW-1:0] v;
        wreg(2'd2, 1'b1, 8'd8);
        wreg(2'd2, 1'b0, 8'h30);
        @(negedge clk);
        op_valid = 1'b1; op_sel = 2'd2; op_code = OP_INC;
        wr_en = 1'b1; wr_field = 1'b0; wr_sel = 2'd2; wr_data = 8'h80;
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        peek(2'd2, v);
        check("R8 load beats update", v, 8'h80);
        @(negedge clk);
        op_valid = 1'b1; op_sel = 2'd2; op_code = OP_INC;
        wr_en = 1'b1; wr_field = 1'b0; wr_sel = 2'd3; wr_data = 8'h11;
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        peek(2'd2, v);
        check("R8 other register still updates", v, 8'h81);
        peek(2'd3, v);
        check("R8 load to other register", v, 8'h11);
        wreg(2'd3, 1'b1, 8'd1);
        issue(2'd3, OP_INC, v);
        peek(2'd3, v);
        check("R8 size field sets 2-entry buffer", v, 8'h10);
    endtask

    task automatic t_idle();
        logic [AW-1:0] v;
        logic          vld;
        @(negedge clk);
        op_valid = 1'b0; op_sel = 2'd2; op_code = OP_INC;
        #1 vld = addr_valid;
        tests++;
        if (vld !== 1'b0) begin
            fails++;
            $display("FAIL R10 addr_valid while idle: got %b expected 0", vld);
        end
        @(negedge clk);
        peek(2'd2, v);
        check("R10 idle leaves register", v, 8'h81);
    endtask

    task automatic t_size_edges();
        logic [AW-1:0] v;
        wreg(2'd1, 1'b1, 8'd0);
        wreg(2'd1, 1'b0, 8'h3A);
        issue(2'd1, OP_INC, v);
        peek(2'd1, v);
        check("R9 zero size holds", v, 8'h3A);
        wreg(2'd1, 1'b1, 8'd7);
        wreg(2'd1, 1'b0, 8'hFF);
        issue(2'd1, OP_INC, v);
        peek(2'd1, v);
        check("R9 size 7 keeps bit 7", v, 8'h80);
        wreg(2'd1, 1'b1, 8'd15);
        wreg(2'd1, 1'b0, 8'hFF);
        issue(2'd1, OP_INC, v);
        peek(2'd1, v);
        check("R9 clamped size wraps full range", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pre_update();
        t_circ_unit();
        t_circ_step();
        t_bitrev();
        t_step_inc();
        t_read_hold();
        t_wr_prio();
        t_idle();
        t_size_edges();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule